// File: doc/BRIEF.md
# Population Count and Bit-Scan Execution Unit

This execution unit accepts one operation per clock on a 64-bit operand and returns a result and a zero flag a fixed three cycles later. It performs three functions: it counts the set bits of the operand, it finds the index of the lowest set bit (forward scan), or it finds the index of the highest set bit (reverse scan). The time taken does not depend on the operand's value.

All three functions share one adder tree that weighs every input bit equally. For a count, the operand enters the tree unchanged. For a scan, an encoding stage first turns the operand into a word whose number of ones equals the wanted index. For a forward scan, this word has ones at every position below the lowest set bit. For a reverse scan, it has ones at every position below the highest set bit.

A scan of a zero operand has no index to report. In that case the unit passes the caller's current destination value through unchanged and raises the zero flag. For this reason the prior destination value is an input to the unit.

Top module: `popscan_unit`

## Requirements
- R1: Operation code 2'b00 (and the spare code 2'b11) counts the set bits of the operand. The count appears zero-extended in the result, and the zero flag is 1 exactly when the operand is zero.
- R2: Operation code 2'b01, on a non-zero operand, returns the index (0 = least significant) of the lowest set bit.
- R3: Operation code 2'b10, on a non-zero operand, returns the index of the highest set bit.
- R4: A scan of a non-zero operand clears the zero flag, and its result is always below the operand width.
- R5: A scan of a zero operand sets the zero flag and returns the destination value presented with that operation, bit for bit.
- R6: An operation presented with the valid input high in clock cycle c (captured at the rising edge that ends c) drives its result and flag, with the valid output high, throughout cycle c+3. The valid output is low three cycles after any cycle with the valid input low.
- R7: One operation is accepted every clock. Operations presented on consecutive cycles, of any mix of codes, leave the unit on consecutive cycles in the same order, each with its own correct result.
- R8: While the active-low reset is held, the valid output, the result and the zero flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Operation code: 00 count, 01 forward scan, 10 reverse scan, 11 count |
| in_operand | input | 64 | Source operand |
| in_dest | input | 64 | Current destination value, returned on a zero-operand scan |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Count, bit index, or the passed-through destination |
| out_zf | output | 1 | Zero flag: operand was zero |

## Verification
Two paths can be active in the same cycle. A zero-operand scan that passes its destination through can sit in the output stage while a count or a non-zero scan is in the tree stage behind it, and the reverse can also happen. The bench provokes this by sending back-to-back runs of mixed codes, with zero operands and random destinations mixed in. It judges each output cycle against its own three-deep queue of expected values. Any leak of a destination value into a neighbouring operation, or any flag carried into the wrong slot, shows up as a mismatch in that exact cycle.

// File: rtl/popscan_pkg.sv
package popscan_pkg;

  typedef enum logic [1:0] {
    OP_COUNT     = 2'b00,
    OP_SCAN_LO   = 2'b01,
    OP_SCAN_HI   = 2'b10,
    OP_COUNT_ALT = 2'b11
  } op_e;

  function automatic logic op_is_scan(op_e op);
    return (op == OP_SCAN_LO) || (op == OP_SCAN_HI);
  endfunction

  // Ones strictly below the lowest set bit of v.
  function automatic logic [63:0] below_lowest64(logic [63:0] v);
    return (v ^ (v - 64'd1)) >> 1;
  endfunction

endpackage

// File: rtl/popscan_encode.sv
module popscan_encode
  import popscan_pkg::*;
#(
  parameter int W = 64
) (
  input  op_e          op,
  input  logic [W-1:0] src,
  output logic [W-1:0] enc,
  output logic         src_zero
);
  localparam int LG = $clog2(W);

  // Forward: ones strictly below the lowest set bit.
  logic [W-1:0] below_lo;
  assign below_lo = (src ^ (src - W'(1))) >> 1;

  // Reverse: smear the highest set bit downward, then drop that bit itself.
  logic [W-1:0] smear [LG+1];
  assign smear[0] = src;
  for (genvar s = 0; s < LG; s++) begin : g_smear
    assign smear[s+1] = smear[s] | (smear[s] >> (1 << s));
  end

  logic [W-1:0] below_hi;
  assign below_hi = smear[LG] >> 1;

  assign src_zero = ~|src;

  always_comb begin
    unique case (op)
      OP_SCAN_LO: enc = below_lo;
      OP_SCAN_HI: enc = below_hi;
      default:    enc = src;
    endcase
  end
endmodule

// File: rtl/popscan_tree.sv
module popscan_tree #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] total
);
  localparam int LG = $clog2(W);
  localparam int P  = 1 << LG;

  // Balanced adder tree, padded to a power of two; every leaf has weight one.
  for (genvar l = 0; l <= LG; l++) begin : g_lvl
    logic [CW-1:0] node [P >> l];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < P; i++) begin : g_in
        if (i < W) begin : g_real
          assign node[i] = CW'(bits[i]);
        end else begin : g_pad
          assign node[i] = '0;
        end
      end
    end else begin : g_sum
      for (genvar i = 0; i < (P >> l); i++) begin : g_add
        assign node[i] = g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
      end
    end
  end

  assign total = g_lvl[LG].node[0];
endmodule

// File: rtl/popscan_unit.sv
module popscan_unit
  import popscan_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_operand,
  input  logic [W-1:0] in_dest,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_zf
);
  localparam int CW = $clog2(W + 1);

  // Rank 1: captured operation.
  logic         cap_v;
  op_e          cap_op;
  logic [W-1:0] cap_src;
  logic [W-1:0] cap_dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_v    <= 1'b0;
      cap_op   <= OP_COUNT;
      cap_src  <= '0;
      cap_dest <= '0;
    end else begin
      cap_v    <= in_valid;
      cap_op   <= op_e'(in_op);
      cap_src  <= in_operand;
      cap_dest <= in_dest;
    end
  end

  // Encoding stage.
  logic [W-1:0] enc_word;
  logic         enc_zero;

  popscan_encode #(.W(W)) u_enc (
    .op       (cap_op),
    .src      (cap_src),
    .enc      (enc_word),
    .src_zero (enc_zero)
  );

  // Rank 2: encoded word.
  logic         tr_v;
  logic         tr_scan;
  logic         tr_zero;
  logic [W-1:0] tr_word;
  logic [W-1:0] tr_dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tr_v    <= 1'b0;
      tr_scan <= 1'b0;
      tr_zero <= 1'b0;
      tr_word <= '0;
      tr_dest <= '0;
    end else begin
      tr_v    <= cap_v;
      tr_scan <= op_is_scan(cap_op);
      tr_zero <= enc_zero;
      tr_word <= enc_word;
      tr_dest <= cap_dest;
    end
  end

  // Shared tree and result selection.
  logic [CW-1:0] tree_sum;

  popscan_tree #(.W(W), .CW(CW)) u_tree (
    .bits  (tr_word),
    .total (tree_sum)
  );

  logic         keep_dest;
  logic [W-1:0] next_result;

  assign keep_dest   = tr_scan && tr_zero;
  assign next_result = keep_dest ? tr_dest : W'(tree_sum);

  // Rank 3: outputs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zf     <= 1'b0;
    end else begin
      out_valid <= tr_v;
      if (tr_v) begin
        out_result <= next_result;
        out_zf     <= tr_zero;
      end
    end
  end
endmodule

// File: rtl/popscan_chk.sv
module popscan_chk
  import popscan_pkg::*;
#(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   in_op,
  input logic [W-1:0] in_operand,
  input logic [W-1:0] in_dest,
  input logic         out_valid,
  input logic [W-1:0] out_result,
  input logic         out_zf
);
  localparam int LG = $clog2(W);

  logic is_scan;
  assign is_scan = (in_op == 2'b01) || (in_op == 2'b10);

  logic [LG-1:0] idx;
  assign idx = out_result[LG-1:0];

  // R6: every accepted operation leaves three cycles later.
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  // R6: no result without an operation.
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);

  // R1: count matches the number of ones in the operand.
  a_r1_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_scan) |-> ##3
      (out_result == W'($countones($past(in_operand, 3))) &&
       out_zf == ($past(in_operand, 3) == '0)));

  // R4: a non-zero scan clears the flag and yields an in-range index.
  a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_scan && (in_operand != '0)) |-> ##3
      (!out_zf && out_result < W));

  // R5: a zero scan keeps the destination value.
  a_r5_keep_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_scan && (in_operand == '0)) |-> ##3
      (out_zf && out_result == $past(in_dest, 3)));

  // R2: the reported bit is set and nothing below it is.
  a_r2_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b01 && (in_operand != '0)) |-> ##3
      (($past(in_operand, 3) << (W - 1 - int'(idx))) == (W'(1) << (W - 1))));

  // R3: the reported bit is set and nothing above it is.
  a_r3_highest: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b10 && (in_operand != '0)) |-> ##3
      (($past(in_operand, 3) >> idx) == W'(1)));
endmodule

bind popscan_unit popscan_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_operand (in_operand),
  .in_dest    (in_dest),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_zf     (out_zf)
);

// File: tb/tb_popscan_unit.sv
module tb_popscan_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   in_op = 2'b00;
  logic [W-1:0] in_operand = '0;
  logic [W-1:0] in_dest = '0;
  logic         out_valid;
  logic [W-1:0] out_result;
  logic         out_zf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic         e_v [3];
  logic [W-1:0] e_r [3];
  logic         e_z [3];
  string        e_t [3];

  always #(CLK_PERIOD / 2) clk = ~clk;

  popscan_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_operand(in_operand), .in_dest(in_dest),
    .out_valid(out_valid), .out_result(out_result), .out_zf(out_zf)
  );

  function automatic int bench_ones(logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic int bench_low(logic [W-1:0] v);
    for (int i = 0; i < W; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int bench_high(logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic note(bit ok, string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_slot();
    note(out_valid === e_v[2], "R6", "valid", W'(out_valid), W'(e_v[2]));
    if (e_v[2]) begin
      note(out_result === e_r[2], e_t[2], "result", out_result, e_r[2]);
      note(out_zf === e_z[2], e_t[2], "zero flag", W'(out_zf), W'(e_z[2]));
    end
  endtask

  task automatic step(bit v, logic [1:0] op, logic [W-1:0] x, logic [W-1:0] d);
    @(negedge clk);
    check_slot();
    for (int k = 2; k > 0; k--) begin
      e_v[k] = e_v[k-1]; e_r[k] = e_r[k-1]; e_z[k] = e_z[k-1]; e_t[k] = e_t[k-1];
    end
    in_valid = v; in_op = op; in_operand = x; in_dest = d;
    e_v[0] = v;
    e_z[0] = (x == '0);
    if (op == 2'b01 || op == 2'b10) begin
      if (x == '0) begin
        e_r[0] = d; e_t[0] = "R5";
      end else if (op == 2'b01) begin
        e_r[0] = W'(bench_low(x)); e_t[0] = "R2";
      end else begin
        e_r[0] = W'(bench_high(x)); e_t[0] = "R3";
      end
    end else begin
      e_r[0] = W'(bench_ones(x)); e_t[0] = "R1";
    end
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3; k++) begin
      e_v[k] = 1'b0; e_r[k] = '0; e_z[k] = 1'b0; e_t[k] = "R6";
    end
    // R8: quiet outputs while reset is held, even with stimulus applied.
    in_valid = 1'b1; in_operand = '1; in_dest = '1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    note(out_valid === 1'b0, "R8", "valid in reset", W'(out_valid), '0);
    note(out_result === '0, "R8", "result in reset", out_result, '0);
    note(out_zf === 1'b0, "R8", "flag in reset", W'(out_zf), '0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    // Directed corner cases on every code (R1 R2 R3 R4 R5).
    for (int op = 0; op < 4; op++) begin
      step(1, 2'(op), '0, 64'hDEAD_BEEF_0123_4567);
      step(1, 2'(op), '0, '0);
      step(1, 2'(op), '1, rnd64());
      step(1, 2'(op), 64'h8000_0000_0000_0000, rnd64());
      step(1, 2'(op), 64'h1, rnd64());
      step(1, 2'(op), 64'h8000_0000_0000_0001, rnd64());
    end
    // Single-bit walk, back to back with codes rotating (R7).
    for (int b = 0; b < W; b++) begin
      for (int op = 0; op < 3; op++) step(1, 2'(op), W'(1) << b, rnd64());
    end
    // Zero scans interleaved with counts and non-zero scans (R5 next to R1).
    for (int i = 0; i < 200; i++) begin
      step(1, 2'(1 + (i % 2)), '0, rnd64());
      step(1, 2'b00, rnd64(), rnd64());
      step(1, 2'(1 + ((i + 1) % 2)), rnd64() | 64'h1, rnd64());
    end
    // Constrained random with idle gaps (R6 R7).
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x;
      int kind;
      kind = $urandom_range(0, 9);
      if (kind == 0) x = '0;
      else if (kind < 4) x = rnd64() & rnd64() & rnd64();
      else if (kind == 4) x = W'(1) << $urandom_range(0, W - 1);
      else x = rnd64();
      step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), x, rnd64());
    end
    repeat (4) step(0, 2'b00, '0, '0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule